// File: doc/BRIEF.md
# Paged SRAM Mapping Table Programmer

This block fills a page-mapping table that translates addresses inside an external-RAM window into physical addresses. There is one table per CPU. A request names:

- a CPU;
- a process ID;
- a virtual base address and a physical base address;
- a page size in kilobytes;
- an entry count.

After a request is accepted, the block checks it in one dedicated cycle. If any check fails, it reports an error status and writes nothing. Otherwise it writes one table entry per clock, with physical page numbers that rise by one from entry to entry. When the run ends, it stores the request's page-mode code for that CPU and pulses `done` together with a status code.

A separate lookup port translates a virtual address through a CPU's table. It uses the page mode most recently committed for that CPU. The result has two parts: the stored page number in the upper bits and the in-page offset bits of the virtual address below it. Each CPU's table is eight regions of 128 slots, held in a RAM that can be inferred as block RAM.

Top module: `sram_map_programmer`

## Requirements
- R1: After reset, `req_ready` is 1 and `busy`, `done` and `lk_rvalid` are 0. Every CPU's page-mode field in `page_mode` is 0. CPU n's field is bits [3n+2:3n].
- R2: The page sizes 32, 16, 8, 4 and 2 KB map to page-mode codes 0, 1, 2, 3 and 4. The page shift is 15 minus the code. On success, only the selected CPU's page-mode field takes the new code.
- R3: A page size other than the five listed ends with status 3.
- R4: If the virtual or the physical base has nonzero bits below the page size, the request ends with status 1.
- R5: The window starts at 0x3F800000 and spans (page size in KB) << 17 bytes. A virtual base outside it ends with status 5. The window end itself is outside.
- R6: Let the region offset be (vaddr & (0x3FFFFF >> code)) >> shift. The request ends with status 6 in either of two cases:
  - the offset plus the count exceeds 8192 / (page size in KB);
  - the region's first slot plus the offset plus the count exceeds 1024 local slots.
- R7: A CPU number of 2 or more, or a process ID of 8 or more, ends with status 7.
- R8: When several checks fail, the status is chosen in this order: 7, then 3, then 1, then 5, then 6. A failed request writes no entry and leaves every page-mode field unchanged.
- R9: Process IDs 0 and 1 share the region at global index 1152. Process ID p from 2 to 7 starts at global index 1024 + 128·p. The entry index is the region start plus the region offset.
- R10: The first entry holds the physical base shifted right by the page shift. Each later entry holds the previous value plus one, at the next index.
- R11: A request is accepted when `req_valid` and `req_ready` are both high. From the next cycle, `busy` is high and `req_ready` is low. `done` pulses for exactly one cycle, N+2 clock edges after acceptance, where N is the entry count on success and 0 on failure.
- R12: A lookup presented with `lk_valid` returns `lk_rvalid` and `lk_paddr` two clock edges later. `lk_paddr` is (entry << shift) OR (vaddr AND (2^shift − 1)), using the CPU's current page mode.
- R13: A write to one CPU's table never changes the other CPU's table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_cpu | input | 2 | CPU select |
| req_pid | input | 4 | Process ID |
| req_vaddr | input | 32 | Virtual base address |
| req_paddr | input | 32 | Physical base address |
| req_size_kb | input | 6 | Page size in KB |
| req_count | input | 12 | Number of entries to write |
| busy | output | 1 | Checking or writing |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 3 | Status code, valid with `done` |
| page_mode | output | 6 | Committed page-mode code per CPU, 3 bits each |
| lk_valid | input | 1 | Lookup request |
| lk_cpu | input | 1 | Lookup CPU |
| lk_pid | input | 3 | Lookup process ID |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_rvalid | output | 1 | Lookup result valid |
| lk_paddr | output | 32 | Translated physical address |

## Verification
The bench builds the block with its default parameters: two CPUs, eight regions of 128 slots, 16-bit entries and a 12-bit count.

The 12-bit count is wide enough to reach both overflow limits:
- the per-size limit, 256 entries at 32 KB;
- the end of the 1024-slot table, with process ID 7 at 2 KB.

Both limits are hit exactly and one entry past. The 2-bit CPU field and the 4-bit process ID field can carry out-of-range values, so the invalid-ID status and its top priority can be driven directly.

// File: rtl/smap_pkg.sv
package smap_pkg;

  localparam int MODE_W = 3;
  localparam int SIZE_W = 6;
  localparam int STAT_W = 3;

  typedef enum logic [STAT_W-1:0] {
    STS_OK       = 3'd0,
    STS_MISALIGN = 3'd1,
    STS_BADSIZE  = 3'd3,
    STS_WINDOW   = 3'd5,
    STS_OVERFLOW = 3'd6,
    STS_BADID    = 3'd7
  } smap_status_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_CHECK,
    S_WRITE,
    S_FIN
  } smap_state_e;

  typedef struct packed {
    logic              ok;
    logic [MODE_W-1:0] mode;
  } smap_size_t;

  // Page size in KB to page-mode code; ok is low for unsupported sizes.
  function automatic smap_size_t size_decode(input logic [SIZE_W-1:0] kb);
    smap_size_t r;
    r.ok   = 1'b1;
    r.mode = '0;
    case (kb)
      6'd32:   r.mode = 3'd0;
      6'd16:   r.mode = 3'd1;
      6'd8:    r.mode = 3'd2;
      6'd4:    r.mode = 3'd3;
      6'd2:    r.mode = 3'd4;
      default: r.ok   = 1'b0;
    endcase
    return r;
  endfunction

  // Page shift in address bits for a page-mode code.
  function automatic logic [4:0] mode_shift(input logic [MODE_W-1:0] mode);
    return 5'd15 - 5'(mode);
  endfunction

endpackage

// File: rtl/smap_check.sv
module smap_check
  import smap_pkg::*;
#(
  parameter int          ADDR_W         = 32,
  parameter int          ENTRY_W        = 16,
  parameter int          COUNT_W        = 12,
  parameter int          CPU_W          = 2,
  parameter int          PID_W          = 4,
  parameter int          NUM_CPU        = 2,
  parameter int          REGIONS        = 8,
  parameter int          SLOT_BITS      = 7,
  parameter int          IDX_W          = 10,
  parameter int          OFS_MASK_W     = 22,
  parameter int          WIN_SPAN_SHIFT = 17,
  parameter int          RAM_KB         = 8192,
  parameter [ADDR_W-1:0] WIN_BASE       = 32'h3F80_0000
) (
  input  logic [CPU_W-1:0]   cpu,
  input  logic [PID_W-1:0]   pid,
  input  logic [ADDR_W-1:0]  vaddr,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [SIZE_W-1:0]  size_kb,
  input  logic [COUNT_W-1:0] count,
  output smap_status_e       status,
  output logic [MODE_W-1:0]  mode,
  output logic [IDX_W-1:0]   start_idx,
  output logic [ENTRY_W-1:0] first_entry
);

  typedef logic [ADDR_W:0] wide_t;

  localparam int          DEPTH        = REGIONS << SLOT_BITS;
  localparam int          LIM_BASE     = RAM_KB / 32;
  localparam [ADDR_W-1:0] OFS_MASK     = ADDR_W'((64'd1 << OFS_MASK_W) - 64'd1);

  smap_size_t        sz;
  logic [4:0]        shift;
  logic [ADDR_W-1:0] low_mask;
  wide_t             win_end;
  logic              in_win;
  logic [ADDR_W-1:0] offset_full;
  logic [ADDR_W-1:0] region_base;
  logic [ADDR_W-1:0] size_limit;
  logic [ADDR_W-1:0] end_full;
  logic              id_bad;
  logic              misaligned;
  logic              overflow;

  always_comb begin
    sz          = size_decode(size_kb);
    mode        = sz.mode;
    shift       = mode_shift(sz.mode);
    low_mask    = (ADDR_W'(1) << shift) - ADDR_W'(1);
    win_end     = wide_t'(WIN_BASE) + (wide_t'(size_kb) << WIN_SPAN_SHIFT);
    in_win      = (wide_t'(vaddr) >= wide_t'(WIN_BASE)) && (wide_t'(vaddr) < win_end);
    offset_full = (vaddr & (OFS_MASK >> sz.mode)) >> shift;
    region_base = (pid <= PID_W'(1)) ? (ADDR_W'(1) << SLOT_BITS)
                                     : (ADDR_W'(pid) << SLOT_BITS);
    size_limit  = ADDR_W'(LIM_BASE) << sz.mode;
    end_full    = region_base + offset_full + ADDR_W'(count);
    id_bad      = (cpu >= CPU_W'(NUM_CPU)) || (pid >= PID_W'(REGIONS));
    misaligned  = ((vaddr & low_mask) != '0) || ((paddr & low_mask) != '0);
    overflow    = ((offset_full + ADDR_W'(count)) > size_limit) ||
                  (end_full > ADDR_W'(DEPTH));

    if (id_bad)           status = STS_BADID;
    else if (!sz.ok)      status = STS_BADSIZE;
    else if (misaligned)  status = STS_MISALIGN;
    else if (!in_win)     status = STS_WINDOW;
    else if (overflow)    status = STS_OVERFLOW;
    else                  status = STS_OK;

    start_idx   = IDX_W'(region_base + offset_full);
    first_entry = ENTRY_W'(paddr >> shift);
  end

endmodule

// File: rtl/smap_ram.sv
module smap_ram #(
  parameter int DEPTH  = 1024,
  parameter int IDX_W  = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/smap_lookup.sv
module smap_lookup
  import smap_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ENTRY_W    = 16,
  parameter int NUM_CPU    = 2,
  parameter int LK_CPU_W   = 1,
  parameter int LK_PID_W   = 3,
  parameter int SLOT_BITS  = 7,
  parameter int IDX_W      = 10,
  parameter int OFS_MASK_W = 22
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        lk_valid,
  input  logic [LK_CPU_W-1:0]         lk_cpu,
  input  logic [LK_PID_W-1:0]         lk_pid,
  input  logic [ADDR_W-1:0]           lk_vaddr,
  input  logic [NUM_CPU*MODE_W-1:0]   page_mode,
  input  logic [NUM_CPU*ENTRY_W-1:0]  rdata_all,
  output logic [IDX_W-1:0]            raddr,
  output logic                        lk_rvalid,
  output logic [ADDR_W-1:0]           lk_paddr
);

  localparam [ADDR_W-1:0] OFS_MASK = ADDR_W'((64'd1 << OFS_MASK_W) - 64'd1);

  logic [MODE_W-1:0]   cur_mode;
  logic [4:0]          cur_shift;
  logic [ADDR_W-1:0]   base;
  logic [ADDR_W-1:0]   offset;
  logic [ADDR_W-1:0]   low_bits;

  logic                v1;
  logic [LK_CPU_W-1:0] cpu1;
  logic [4:0]          shift1;
  logic [ADDR_W-1:0]   low1;
  logic [ENTRY_W-1:0]  rsel;

  always_comb begin
    cur_mode  = page_mode[lk_cpu*MODE_W +: MODE_W];
    cur_shift = mode_shift(cur_mode);
    base      = (lk_pid <= LK_PID_W'(1)) ? (ADDR_W'(1) << SLOT_BITS)
                                          : (ADDR_W'(lk_pid) << SLOT_BITS);
    offset    = (lk_vaddr & (OFS_MASK >> cur_mode)) >> cur_shift;
    raddr     = IDX_W'(base + offset);
    low_bits  = lk_vaddr & ((ADDR_W'(1) << cur_shift) - ADDR_W'(1));
    rsel      = rdata_all[cpu1*ENTRY_W +: ENTRY_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1        <= 1'b0;
      cpu1      <= '0;
      shift1    <= '0;
      low1      <= '0;
      lk_rvalid <= 1'b0;
      lk_paddr  <= '0;
    end else begin
      v1        <= lk_valid;
      cpu1      <= lk_cpu;
      shift1    <= cur_shift;
      low1      <= low_bits;
      lk_rvalid <= v1;
      lk_paddr  <= (ADDR_W'(rsel) << shift1) | low1;
    end
  end

endmodule

// File: rtl/sram_map_programmer.sv
module sram_map_programmer
  import smap_pkg::*;
#(
  parameter int          ADDR_W         = 32,
  parameter int          ENTRY_W        = 16,
  parameter int          COUNT_W        = 12,
  parameter int          NUM_CPU        = 2,
  parameter int          CPU_W          = 2,
  parameter int          PID_W          = 4,
  parameter int          REGIONS        = 8,
  parameter int          SLOT_BITS      = 7,
  parameter int          OFS_MASK_W     = 22,
  parameter int          WIN_SPAN_SHIFT = 17,
  parameter int          RAM_KB         = 8192,
  parameter [ADDR_W-1:0] WIN_BASE       = 32'h3F80_0000,
  localparam int         DEPTH          = REGIONS << SLOT_BITS,
  localparam int         IDX_W          = $clog2(DEPTH),
  localparam int         LK_CPU_W       = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int         LK_PID_W       = (REGIONS > 1) ? $clog2(REGIONS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [CPU_W-1:0]           req_cpu,
  input  logic [PID_W-1:0]           req_pid,
  input  logic [ADDR_W-1:0]          req_vaddr,
  input  logic [ADDR_W-1:0]          req_paddr,
  input  logic [SIZE_W-1:0]          req_size_kb,
  input  logic [COUNT_W-1:0]         req_count,
  output logic                       busy,
  output logic                       done,
  output logic [STAT_W-1:0]          done_status,
  output logic [NUM_CPU*MODE_W-1:0]  page_mode,
  input  logic                       lk_valid,
  input  logic [LK_CPU_W-1:0]        lk_cpu,
  input  logic [LK_PID_W-1:0]        lk_pid,
  input  logic [ADDR_W-1:0]          lk_vaddr,
  output logic                       lk_rvalid,
  output logic [ADDR_W-1:0]          lk_paddr
);

  smap_state_e        st;
  logic [CPU_W-1:0]   r_cpu;
  logic [PID_W-1:0]   r_pid;
  logic [ADDR_W-1:0]  r_vaddr;
  logic [ADDR_W-1:0]  r_paddr;
  logic [SIZE_W-1:0]  r_size;
  logic [COUNT_W-1:0] r_count;

  smap_status_e       chk_status;
  logic [MODE_W-1:0]  chk_mode;
  logic [IDX_W-1:0]   chk_idx;
  logic [ENTRY_W-1:0] chk_entry;

  smap_status_e       run_status;
  logic [MODE_W-1:0]  run_mode;
  logic [IDX_W-1:0]   wr_idx;
  logic [ENTRY_W-1:0] wr_val;
  logic [COUNT_W-1:0] remaining;
  logic               wr_en;

  logic [NUM_CPU-1:0][MODE_W-1:0] mode_q;
  logic [IDX_W-1:0]               lk_raddr;
  logic [NUM_CPU*ENTRY_W-1:0]     lk_rdata;

  smap_check #(
    .ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W), .COUNT_W(COUNT_W), .CPU_W(CPU_W),
    .PID_W(PID_W), .NUM_CPU(NUM_CPU), .REGIONS(REGIONS), .SLOT_BITS(SLOT_BITS),
    .IDX_W(IDX_W), .OFS_MASK_W(OFS_MASK_W), .WIN_SPAN_SHIFT(WIN_SPAN_SHIFT),
    .RAM_KB(RAM_KB), .WIN_BASE(WIN_BASE)
  ) u_check (
    .cpu        (r_cpu),
    .pid        (r_pid),
    .vaddr      (r_vaddr),
    .paddr      (r_paddr),
    .size_kb    (r_size),
    .count      (r_count),
    .status     (chk_status),
    .mode       (chk_mode),
    .start_idx  (chk_idx),
    .first_entry(chk_entry)
  );

  assign wr_en     = (st == S_WRITE);
  assign busy      = (st != S_IDLE);
  assign req_ready = (st == S_IDLE);
  assign page_mode = mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      r_cpu       <= '0;
      r_pid       <= '0;
      r_vaddr     <= '0;
      r_paddr     <= '0;
      r_size      <= '0;
      r_count     <= '0;
      run_status  <= STS_OK;
      run_mode    <= '0;
      wr_idx      <= '0;
      wr_val      <= '0;
      remaining   <= '0;
      done        <= 1'b0;
      done_status <= '0;
      mode_q      <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            r_cpu   <= req_cpu;
            r_pid   <= req_pid;
            r_vaddr <= req_vaddr;
            r_paddr <= req_paddr;
            r_size  <= req_size_kb;
            r_count <= req_count;
            st      <= S_CHECK;
          end
        end
        S_CHECK: begin
          run_status <= chk_status;
          run_mode   <= chk_mode;
          wr_idx     <= chk_idx;
          wr_val     <= chk_entry;
          remaining  <= r_count;
          if (chk_status != STS_OK || r_count == '0) st <= S_FIN;
          else                                       st <= S_WRITE;
        end
        S_WRITE: begin
          wr_idx    <= wr_idx + IDX_W'(1);
          wr_val    <= wr_val + ENTRY_W'(1);
          remaining <= remaining - COUNT_W'(1);
          if (remaining == COUNT_W'(1)) st <= S_FIN;
        end
        S_FIN: begin
          done        <= 1'b1;
          done_status <= run_status;
          if (run_status == STS_OK) mode_q[LK_CPU_W'(r_cpu)] <= run_mode;
          st          <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_table
    smap_ram #(
      .DEPTH (DEPTH),
      .IDX_W (IDX_W),
      .DATA_W(ENTRY_W)
    ) u_ram (
      .clk  (clk),
      .we   (wr_en && (r_cpu == CPU_W'(g))),
      .waddr(wr_idx),
      .wdata(wr_val),
      .raddr(lk_raddr),
      .rdata(lk_rdata[g*ENTRY_W +: ENTRY_W])
    );
  end

  smap_lookup #(
    .ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W), .NUM_CPU(NUM_CPU), .LK_CPU_W(LK_CPU_W),
    .LK_PID_W(LK_PID_W), .SLOT_BITS(SLOT_BITS), .IDX_W(IDX_W),
    .OFS_MASK_W(OFS_MASK_W)
  ) u_lookup (
    .clk      (clk),
    .rst      (rst),
    .lk_valid (lk_valid),
    .lk_cpu   (lk_cpu),
    .lk_pid   (lk_pid),
    .lk_vaddr (lk_vaddr),
    .page_mode(mode_q),
    .rdata_all(lk_rdata),
    .raddr    (lk_raddr),
    .lk_rvalid(lk_rvalid),
    .lk_paddr (lk_paddr)
  );

endmodule

// File: rtl/smap_chk.sv
module smap_chk #(
  parameter int NUM_CPU = 2,
  parameter int MODE_W  = 3,
  parameter int STAT_W  = 3
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic                      busy,
  input logic                      done,
  input logic [STAT_W-1:0]         done_status,
  input logic [NUM_CPU*MODE_W-1:0] page_mode,
  input logic                      wr_en,
  input logic                      lk_valid,
  input logic                      lk_rvalid
);

  // R11
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> busy);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  write_busy_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (busy && !done));

  // R8
  err_mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && done_status != '0) |-> (page_mode == $past(page_mode)));

  // R12
  lookup_lat_chk: assert property (@(posedge clk) disable iff (rst)
    lk_rvalid |-> $past(lk_valid, 2));

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_mode
    // R2
    mode_range_chk: assert property (@(posedge clk) disable iff (rst)
      page_mode[g*MODE_W +: MODE_W] <= MODE_W'(4));
  end

endmodule

bind sram_map_programmer smap_chk #(
  .NUM_CPU(NUM_CPU),
  .MODE_W (smap_pkg::MODE_W),
  .STAT_W (smap_pkg::STAT_W)
) u_smap_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .busy       (busy),
  .done       (done),
  .done_status(done_status),
  .page_mode  (page_mode),
  .wr_en      (wr_en),
  .lk_valid   (lk_valid),
  .lk_rvalid  (lk_rvalid)
);

// File: tb/tb_sram_map_programmer.sv
module tb_sram_map_programmer;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_cpu;
  logic [3:0]  req_pid;
  logic [31:0] req_vaddr;
  logic [31:0] req_paddr;
  logic [5:0]  req_size_kb;
  logic [11:0] req_count;
  logic        busy;
  logic        done;
  logic [2:0]  done_status;
  logic [5:0]  page_mode;
  logic        lk_valid;
  logic        lk_cpu;
  logic [2:0]  lk_pid;
  logic [31:0] lk_vaddr;
  logic        lk_rvalid;
  logic [31:0] lk_paddr;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  sram_map_programmer dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_cpu(req_cpu), .req_pid(req_pid),
    .req_vaddr(req_vaddr), .req_paddr(req_paddr),
    .req_size_kb(req_size_kb), .req_count(req_count),
    .busy(busy), .done(done), .done_status(done_status),
    .page_mode(page_mode),
    .lk_valid(lk_valid), .lk_cpu(lk_cpu), .lk_pid(lk_pid),
    .lk_vaddr(lk_vaddr), .lk_rvalid(lk_rvalid), .lk_paddr(lk_paddr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Issue one request; check status and done latency.
  task automatic do_req(input logic [1:0] cpu, input logic [3:0] pid,
                        input logic [31:0] va, input logic [31:0] pa,
                        input logic [5:0] kb, input logic [11:0] cnt,
                        input logic [2:0] exp_st, input int exp_lat,
                        input string tag);
    int n;
    @(negedge clk);
    chk(req_ready === 1'b1, {tag, " ready before request"}, 32'(req_ready), 1);
    req_valid = 1'b1; req_cpu = cpu; req_pid = pid; req_vaddr = va;
    req_paddr = pa; req_size_kb = kb; req_count = cnt;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    // R11: busy and not ready after acceptance
    chk(busy === 1'b1 && req_ready === 1'b0, {tag, " R11 busy after accept"},
        {30'd0, busy, req_ready}, 32'h2);
    n = 0;
    while (n < 5000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (done === 1'b1) break;
    end
    chk(done_status === exp_st, {tag, " status"}, 32'(done_status), 32'(exp_st));
    chk(n == exp_lat, {tag, " R11 done latency"}, 32'(n), 32'(exp_lat));
    @(negedge clk);
    chk(done === 1'b0, {tag, " R11 done single pulse"}, 32'(done), 0);
  endtask

  // Translate one address; check two-cycle latency and result.
  task automatic do_lookup(input logic cpu, input logic [2:0] pid,
                           input logic [31:0] va, input logic [31:0] exp,
                           input string tag);
    @(negedge clk);
    lk_valid = 1'b1; lk_cpu = cpu; lk_pid = pid; lk_vaddr = va;
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    chk(lk_rvalid === 1'b0, {tag, " R12 not yet valid"}, 32'(lk_rvalid), 0);
    @(posedge clk);
    @(negedge clk);
    chk(lk_rvalid === 1'b1, {tag, " R12 valid after two edges"}, 32'(lk_rvalid), 1);
    chk(lk_paddr === exp, {tag, " lookup address"}, lk_paddr, exp);
  endtask

  task automatic t_reset;
    // R1
    chk(req_ready === 1'b1, "R1 ready", 32'(req_ready), 1);
    chk(busy === 1'b0 && done === 1'b0, "R1 busy/done idle", {30'd0, busy, done}, 0);
    chk(page_mode === 6'd0, "R1 page modes", 32'(page_mode), 0);
    chk(lk_rvalid === 1'b0, "R1 lookup idle", 32'(lk_rvalid), 0);
  endtask

  task automatic t_basic_4k;
    // R2 R9 R10: 4 KB, cpu0 pid3, offset 5, entries 0x40..0x43
    do_req(2'd0, 4'd3, 32'h3F80_5000, 32'h0004_0000, 6'd4, 12'd4, 3'd0, 6, "R10 basic 4KB");
    chk(page_mode[2:0] === 3'd3, "R2 cpu0 mode 4KB", 32'(page_mode[2:0]), 3);
    chk(page_mode[5:3] === 3'd0, "R2 cpu1 mode untouched", 32'(page_mode[5:3]), 0);
    do_lookup(1'b0, 3'd3, 32'h3F80_5000, 32'h0004_0000, "R10 first entry");
    do_lookup(1'b0, 3'd3, 32'h3F80_6123, 32'h0004_1123, "R12 entry plus offset");
    do_lookup(1'b0, 3'd3, 32'h3F80_8ABC, 32'h0004_3ABC, "R10 last entry");
  endtask

  task automatic t_errors;
    do_req(2'd0, 4'd3, 32'h3F80_5000, 32'h0004_0000, 6'd12, 12'd1, 3'd3, 2, "R3 size 12");
    do_req(2'd0, 4'd3, 32'h3F80_5000, 32'h0004_0000, 6'd0,  12'd1, 3'd3, 2, "R3 size 0");
    do_req(2'd0, 4'd3, 32'h3F80_5800, 32'h0004_0000, 6'd4,  12'd1, 3'd1, 2, "R4 vaddr misaligned");
    do_req(2'd0, 4'd3, 32'h3F80_5000, 32'h0004_0010, 6'd4,  12'd1, 3'd1, 2, "R4 paddr misaligned");
    do_req(2'd0, 4'd3, 32'h3F90_0000, 32'h0004_0000, 6'd8,  12'd1, 3'd5, 2, "R5 window end");
    do_req(2'd0, 4'd3, 32'h3F7F_E000, 32'h0004_0000, 6'd8,  12'd1, 3'd5, 2, "R5 below window");
    do_req(2'd0, 4'd3, 32'h3F80_5000, 32'h0090_0000, 6'd4,  12'd2100, 3'd6, 2, "R6 overflow");
    do_req(2'd2, 4'd3, 32'h3F80_5000, 32'h0004_0000, 6'd4,  12'd1, 3'd7, 2, "R7 cpu 2");
    do_req(2'd0, 4'd8, 32'h3F80_5000, 32'h0004_0000, 6'd4,  12'd1, 3'd7, 2, "R7 pid 8");
    do_req(2'd3, 4'd3, 32'h3F80_5000, 32'h0004_0000, 6'd12, 12'd1, 3'd7, 2, "R8 id over size");
    do_req(2'd0, 4'd3, 32'h3F80_5800, 32'h0004_0000, 6'd12, 12'd1, 3'd3, 2, "R8 size over align");
    do_req(2'd0, 4'd3, 32'h3F90_0800, 32'h0004_0000, 6'd4,  12'd1, 3'd1, 2, "R8 align over window");
    do_req(2'd0, 4'd3, 32'h3F90_0000, 32'h0004_0000, 6'd8,  12'd4000, 3'd5, 2, "R8 window over overflow");
    // R8: nothing changed by failed requests
    chk(page_mode === 6'b000_011, "R8 modes unchanged", 32'(page_mode), 32'h3);
    do_lookup(1'b0, 3'd3, 32'h3F80_5000, 32'h0004_0000, "R8 entry kept");
  endtask

  task automatic t_cpu1;
    // R9: pid0 writes the region pid1 reads; 16 KB mode 1
    do_req(2'd1, 4'd0, 32'h3F80_8000, 32'h0010_0000, 6'd16, 12'd3, 3'd0, 5, "R9 cpu1 pid0");
    chk(page_mode[5:3] === 3'd1, "R2 cpu1 mode 16KB", 32'(page_mode[5:3]), 1);
    chk(page_mode[2:0] === 3'd3, "R2 cpu0 mode kept", 32'(page_mode[2:0]), 3);
    do_lookup(1'b1, 3'd1, 32'h3F80_C010, 32'h0010_4010, "R9 pid1 shares pid0");
    // R13: cpu1 pid3 offset 5 must not disturb cpu0 pid3 offset 5
    do_req(2'd1, 4'd3, 32'h3F81_4000, 32'h0020_0000, 6'd16, 12'd2, 3'd0, 4, "R13 cpu1 pid3");
    do_lookup(1'b1, 3'd3, 32'h3F81_4044, 32'h0020_0044, "R13 cpu1 entry");
    do_lookup(1'b0, 3'd3, 32'h3F80_5000, 32'h0004_0000, "R13 cpu0 entry intact");
    // count zero: success, mode updated
    do_req(2'd1, 4'd4, 32'h3F80_0000, 32'h0000_0000, 6'd4, 12'd0, 3'd0, 2, "R11 count zero");
    chk(page_mode[5:3] === 3'd3, "R2 cpu1 mode after count zero", 32'(page_mode[5:3]), 3);
  endtask

  task automatic t_bounds;
    do_req(2'd0, 4'd2, 32'h3FBF_8000, 32'h0080_0000, 6'd32, 12'd1, 3'd0, 3, "R5 last 32KB page");
    chk(page_mode[2:0] === 3'd0, "R2 cpu0 mode 32KB", 32'(page_mode[2:0]), 0);
    do_lookup(1'b0, 3'd2, 32'h3FBF_FFFF, 32'h0080_7FFF, "R12 32KB lookup");
    do_req(2'd0, 4'd2, 32'h3FC0_0000, 32'h0080_0000, 6'd32, 12'd1, 3'd5, 2, "R5 32KB window end");
    do_req(2'd0, 4'd5, 32'h3F80_0000, 32'h0000_0000, 6'd32, 12'd256, 3'd0, 258, "R6 size limit exact");
    do_req(2'd0, 4'd5, 32'h3F80_0000, 32'h0000_0000, 6'd32, 12'd257, 3'd6, 2, "R6 size limit plus one");
    do_req(2'd1, 4'd7, 32'h3F83_2000, 32'h0000_1000, 6'd2, 12'd28, 3'd0, 30, "R6 table end exact");
    chk(page_mode[5:3] === 3'd4, "R2 cpu1 mode 2KB", 32'(page_mode[5:3]), 4);
    do_lookup(1'b1, 3'd7, 32'h3F83_FFFF, 32'h0000_EFFF, "R10 last table slot");
    do_req(2'd1, 4'd7, 32'h3F83_2000, 32'h0000_1000, 6'd2, 12'd29, 3'd6, 2, "R6 table end plus one");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_cpu = '0; req_pid = '0; req_vaddr = '0;
    req_paddr = '0; req_size_kb = '0; req_count = '0;
    lk_valid = 1'b0; lk_cpu = 1'b0; lk_pid = '0; lk_vaddr = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic_4k();
    t_errors();
    t_cpu1();
    t_bounds();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule